// File: doc/BRIEF.md
# Decimating Two-Pole Sample-Rate Reduction Filter

This block is a fixed-point model of a cascaded discrete-time receive filter. It takes one signed sample on each clock where the input strobe is high. The first stage adds the samples of each block of N accepted samples and emits one block total. That total drives a one-pole recursion whose output is a leaked share of the state held before the update. A group stage then adds four consecutive recursion outputs. The last stage is a one-pole recursion that scales the sum of its state and its input by a second coefficient. The output rate is the accepted-sample rate divided by 4·N.

The block ratio N can be changed while samples are flowing, so that alias bands can be moved. A new ratio is taken up only where a block ends. The partial sums held at that point are dropped, and the next output is flagged as settling. Both coefficients are unsigned Q1.15 values. Every product is rounded to the nearest integer, and all state is kept in wide registers that clamp instead of wrapping.

Top module: `dt_filter_chain`

## Requirements
- R1: A synchronous reset clears every partial sum, both recursion states, the output strobe, the output value and the settling flag. After reset the block ratio is 8.
- R2: A block total is the exact sum of N accepted samples, where a sample is accepted on a clock with `in_valid` high. Clocks with `in_valid` low neither count nor add.
- R3: For each block total w, the first recursion outputs x = (1 − a1)·s_prev and then updates s = a1·s_prev + w. The output uses the state held before the update.
- R4: The group stage adds four consecutive x values and emits one sum y for each four. The output strobe is never high on two consecutive clocks.
- R5: The last stage updates z = a2·(z_prev + y) and presents z as `out_data`.
- R6: A coefficient port value c means c/32768, so 31740 ≈ 0.9686 and 28652 ≈ 0.8744. Products are rounded to nearest. With a constant input d, the output settles to 4·N·d·a2/(1 − a2).
- R7: `out_valid` is high for one clock, in the cycle that follows the third rising edge after the edge that accepted the last sample of the group.
- R8: If the clamped ratio differs from the current N at the edge that accepts the last sample of a block, that block total and the partial group sum are both dropped. The new N applies from the next accepted sample.
- R9: `out_settling` is 1 on the first output after a ratio change and 0 on every other output.
- R10: A ratio below 7 is treated as 7 and a ratio above 9 is treated as 9. A request that clamps to the current N is not a change.
- R11: `out_data` clamps to the range −8388608 to 8388607 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| ratio | input | 4 | Requested block ratio N |
| coef_a1 | input | 16 | First recursion coefficient, unsigned Q1.15 |
| coef_a2 | input | 16 | Second recursion coefficient, unsigned Q1.15 |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 24 | Signed, clamped output sample |
| out_settling | output | 1 | Marks the first output after a ratio change |

## Verification
Each output is due exactly three rising edges after the edge that accepts the last sample of its group. One edge each goes to the block total, the first recursion, the group sum and the last recursion. When a sample completes a group, the bench's reference model enters the expected value, the expected flag and the cycle index of that due edge into a queue. A monitor samples on falling edges only. It requires `out_valid` in exactly that cycle and treats a strobe at any other time as a miscompare. Values are compared within a tolerance derived from the rounding gain 1/(1 − a2).

// File: rtl/dtf_pkg.sv
package dtf_pkg;

  localparam int COEF_W = 16;
  localparam int FRAC_W = 15;

  // Rounded Q1.15 product: v * c / 2^15, rounded to nearest.
  function automatic logic signed [63:0] q15_scale(input logic signed [63:0] v,
                                                   input logic signed [COEF_W+1:0] c);
    logic signed [63:0] cw;
    logic signed [63:0] p;
    cw = c;
    p  = v * cw;
    return (p + (64'sd1 <<< (FRAC_W - 1))) >>> FRAC_W;
  endfunction

  // Clamp v to the signed range of a w-bit word.
  function automatic logic signed [63:0] clamp_to(input logic signed [63:0] v, input int w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/dtf_block_sum.sv
module dtf_block_sum #(
  parameter int IN_W  = 16,
  parameter int N_MIN = 7,
  parameter int N_MAX = 9,
  parameter int N_DEF = 8,
  localparam int CNT_W = $clog2(N_MAX + 1),
  localparam int SUM_W = IN_W + CNT_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  input  logic [CNT_W-1:0]        ratio,
  output logic                    sum_valid,
  output logic signed [SUM_W-1:0] sum_data,
  output logic                    restart
);

  logic [CNT_W-1:0]        n_cur;
  logic [CNT_W-1:0]        cnt;
  logic [CNT_W-1:0]        n_req;
  logic signed [SUM_W-1:0] acc;
  logic signed [SUM_W-1:0] in_ext;
  logic                    blk_last;

  assign in_ext   = SUM_W'(in_data);
  assign blk_last = in_valid && (cnt == n_cur - CNT_W'(1));

  always_comb begin
    if (ratio < CNT_W'(N_MIN))      n_req = CNT_W'(N_MIN);
    else if (ratio > CNT_W'(N_MAX)) n_req = CNT_W'(N_MAX);
    else                            n_req = ratio;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      n_cur     <= CNT_W'(N_DEF);
      cnt       <= '0;
      acc       <= '0;
      sum_valid <= 1'b0;
      sum_data  <= '0;
      restart   <= 1'b0;
    end else begin
      sum_valid <= 1'b0;
      restart   <= 1'b0;
      if (blk_last) begin
        cnt <= '0;
        acc <= '0;
        if (n_req != n_cur) begin
          n_cur   <= n_req;
          restart <= 1'b1;
        end else begin
          sum_valid <= 1'b1;
          sum_data  <= acc + in_ext;
        end
      end else if (in_valid) begin
        cnt <= cnt + CNT_W'(1);
        acc <= acc + in_ext;
      end
    end
  end

endmodule

// File: rtl/dtf_pole.sv
module dtf_pole
  import dtf_pkg::*;
#(
  parameter int W    = 32,
  parameter int MODE = 0   // 0: leaked previous state out, 1: scaled state and input
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_data,
  input  logic [COEF_W-1:0]   coef,
  output logic                out_valid,
  output logic signed [W-1:0] out_data
);

  logic signed [W-1:0]      st;
  logic signed [63:0]       st_w;
  logic signed [63:0]       in_w;
  logic signed [COEF_W+1:0] c_keep;

  assign st_w   = st;
  assign in_w   = in_data;
  assign c_keep = $signed({2'b00, coef});

  generate
    if (MODE == 0) begin : g_leaky
      logic signed [COEF_W+1:0] c_leak;
      assign c_leak = (18'sd1 <<< FRAC_W) - c_keep;
      always_ff @(posedge clk) begin
        if (rst) begin
          st        <= '0;
          out_valid <= 1'b0;
          out_data  <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            out_data <= W'(clamp_to(q15_scale(st_w, c_leak), W));
            st       <= W'(clamp_to(q15_scale(st_w, c_keep) + in_w, W));
          end
        end
      end
    end else begin : g_scaled
      always_ff @(posedge clk) begin
        if (rst) begin
          st        <= '0;
          out_valid <= 1'b0;
          out_data  <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            st       <= W'(clamp_to(q15_scale(st_w + in_w, c_keep), W));
            out_data <= W'(clamp_to(q15_scale(st_w + in_w, c_keep), W));
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/dtf_group_sum.sv
module dtf_group_sum
  import dtf_pkg::*;
#(
  parameter int W = 32,
  parameter int M = 4,
  localparam int CNT_W = (M > 2) ? $clog2(M) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_data,
  input  logic                restart,
  output logic                out_valid,
  output logic signed [W-1:0] out_data,
  output logic                out_fresh
);

  logic [CNT_W-1:0]    cnt;
  logic signed [W-1:0] acc;
  logic                armed;
  logic signed [63:0]  sum_w;

  assign sum_w = clamp_to(64'(acc) + 64'(in_data), W);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      acc       <= '0;
      armed     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_fresh <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (restart) begin
        cnt   <= '0;
        acc   <= '0;
        armed <= 1'b1;
      end else if (in_valid) begin
        if (cnt == CNT_W'(M - 1)) begin
          out_valid <= 1'b1;
          out_data  <= W'(sum_w);
          out_fresh <= armed;
          armed     <= 1'b0;
          cnt       <= '0;
          acc       <= '0;
        end else begin
          cnt <= cnt + CNT_W'(1);
          acc <= W'(sum_w);
        end
      end
    end
  end

endmodule

// File: rtl/dt_filter_chain.sv
module dt_filter_chain
  import dtf_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 24,
  parameter int ACC_W = 32,
  parameter int N_MIN = 7,
  parameter int N_MAX = 9,
  parameter int N_DEF = 8,
  parameter int M     = 4,
  localparam int RATIO_W = $clog2(N_MAX + 1),
  localparam int SUM_W   = IN_W + RATIO_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  input  logic [RATIO_W-1:0]      ratio,
  input  logic [COEF_W-1:0]       coef_a1,
  input  logic [COEF_W-1:0]       coef_a2,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data,
  output logic                    out_settling
);

  // Named internal events, brought out for the checker.
  logic                    w_valid;
  logic signed [SUM_W-1:0] w_data;
  logic signed [ACC_W-1:0] w_ext;
  logic                    restart;
  logic                    x_valid;
  logic signed [ACC_W-1:0] x_data;
  logic                    y_valid;
  logic signed [ACC_W-1:0] y_data;
  logic                    y_fresh;
  logic signed [ACC_W-1:0] z_data;

  dtf_block_sum #(.IN_W(IN_W), .N_MIN(N_MIN), .N_MAX(N_MAX), .N_DEF(N_DEF)) u_blk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .ratio(ratio),
    .sum_valid(w_valid), .sum_data(w_data), .restart(restart)
  );

  assign w_ext = ACC_W'(w_data);

  dtf_pole #(.W(ACC_W), .MODE(0)) u_pole1 (
    .clk(clk), .rst(rst), .in_valid(w_valid), .in_data(w_ext), .coef(coef_a1),
    .out_valid(x_valid), .out_data(x_data)
  );

  dtf_group_sum #(.W(ACC_W), .M(M)) u_grp (
    .clk(clk), .rst(rst), .in_valid(x_valid), .in_data(x_data), .restart(restart),
    .out_valid(y_valid), .out_data(y_data), .out_fresh(y_fresh)
  );

  dtf_pole #(.W(ACC_W), .MODE(1)) u_pole2 (
    .clk(clk), .rst(rst), .in_valid(y_valid), .in_data(y_data), .coef(coef_a2),
    .out_valid(out_valid), .out_data(z_data)
  );

  always_ff @(posedge clk) begin
    if (rst)          out_settling <= 1'b0;
    else if (y_valid) out_settling <= y_fresh;
  end

  assign out_data = OUT_W'(clamp_to(64'(z_data), OUT_W));

endmodule

// File: rtl/dtf_chain_checker.sv
module dtf_chain_checker #(
  parameter int OUT_W = 24
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    w_valid,
  input logic                    restart,
  input logic                    x_valid,
  input logic                    y_valid,
  input logic                    out_valid,
  input logic                    out_settling,
  input logic signed [OUT_W-1:0] out_data
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0 && !out_settling));

  assert_block_single_R2: assert property (@(posedge clk) disable iff (rst)
    w_valid |=> !w_valid);

  assert_pole_step_R3: assert property (@(posedge clk) disable iff (rst)
    w_valid |=> x_valid);

  assert_out_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_out_latency_R7: assert property (@(posedge clk) disable iff (rst)
    y_valid |=> out_valid);

  assert_drop_block_R8: assert property (@(posedge clk) disable iff (rst)
    restart |-> !w_valid);

  assert_settle_with_out_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(out_settling) |-> out_valid);

endmodule

bind dt_filter_chain dtf_chain_checker #(.OUT_W(OUT_W)) u_chain_chk (
  .clk(clk), .rst(rst), .w_valid(w_valid), .restart(restart), .x_valid(x_valid),
  .y_valid(y_valid), .out_valid(out_valid), .out_settling(out_settling), .out_data(out_data)
);

// File: tb/test_dt_filter_chain.sv
`timescale 1ns/1ps
module test_dt_filter_chain;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic [3:0]         ratio = 4'd8;
  logic [15:0]        coef_a1 = 16'd31740;
  logic [15:0]        coef_a2 = 16'd28652;
  logic               out_valid;
  logic signed [23:0] out_data;
  logic               out_settling;

  dt_filter_chain i_dt_filter_chain (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .ratio(ratio),
    .coef_a1(coef_a1), .coef_a2(coef_a2), .out_valid(out_valid), .out_data(out_data),
    .out_settling(out_settling)
  );

  always #4 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;
  string cur_tag = "R5";

  always @(posedge clk) cyc <= cyc + 1;

  // Real-valued reference model.
  real m_s, m_z, m_blk, m_grp;
  int  m_bcnt, m_gcnt, m_ncur;
  bit  m_settle;
  real exp_q[$];
  int  due_q[$];
  bit  flag_q[$];

  function automatic real clampr(input real v);
    if (v > 8388607.0) return 8388607.0;
    if (v < -8388608.0) return -8388608.0;
    return v;
  endfunction

  function automatic real tol();
    return 16.0 + 8.0 / (1.0 - real'(coef_a2) / 32768.0);
  endfunction

  task automatic model_clear();
    m_s = 0.0; m_z = 0.0; m_blk = 0.0; m_grp = 0.0;
    m_bcnt = 0; m_gcnt = 0; m_ncur = 8; m_settle = 0;
    exp_q.delete(); due_q.delete(); flag_q.delete();
  endtask

  task automatic model_step(input int v, input int acc_cyc);
    int  eff;
    real a1, a2, x;
    a1  = real'(coef_a1) / 32768.0;
    a2  = real'(coef_a2) / 32768.0;
    eff = (ratio < 4'd7) ? 7 : ((ratio > 4'd9) ? 9 : int'(ratio));  // R10
    m_bcnt++;
    m_blk += real'(v);
    if (m_bcnt == m_ncur) begin
      m_bcnt = 0;
      if (eff != m_ncur) begin                 // R8: drop block and group partial
        m_ncur = eff; m_blk = 0.0; m_grp = 0.0; m_gcnt = 0; m_settle = 1;
      end else begin
        x = (1.0 - a1) * m_s;                  // R3: previous state
        m_s = a1 * m_s + m_blk;
        m_blk = 0.0;
        m_grp += x;
        m_gcnt++;
        if (m_gcnt == 4) begin                 // R4
          m_z = a2 * (m_z + m_grp);            // R5
          m_grp = 0.0; m_gcnt = 0;
          exp_q.push_back(clampr(m_z));        // R11
          due_q.push_back(acc_cyc + 3);        // R7
          flag_q.push_back(m_settle);          // R9
          m_settle = 0;
        end
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input real act, input real expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0f expected %0f at cycle %0d", req, act, expv, cyc);
    end
  endtask

  // Output monitor, sampling on falling edges.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (due_q.size() > 0 && cyc == due_q[0]) begin
        check(out_valid == 1'b1, "R7", real'(out_valid), 1.0);
        if (out_valid) begin
          check((real'(out_data) - exp_q[0] <= tol()) && (exp_q[0] - real'(out_data) <= tol()),
                cur_tag, real'(out_data), exp_q[0]);
          check(out_settling == flag_q[0], "R9", real'(out_settling), real'(flag_q[0]));
        end
        void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(flag_q.pop_front());
      end else if (out_valid) begin
        check(1'b0, "R7", 1.0, 0.0);
      end
    end
  end

  task automatic push(input int v);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'(v);
    model_step(v, cyc + 1);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    idle(6);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", real'(out_valid), 0.0);
    check(out_data == '0, "R1", real'(out_data), 0.0);
    check(out_settling == 1'b0, "R1", real'(out_settling), 0.0);
    model_clear();
    rst = 1'b0;
  endtask

  // R2 R3 R4 R5 R6: constant input, steady value checked against 4*N*d*a2/(1-a2).
  task automatic t_dc();
    real a2, ideal;
    cur_tag = "R6";
    do_reset();
    for (int i = 0; i < 32 * 100; i++) push(1000);
    idle(6);
    a2 = real'(coef_a2) / 32768.0;
    ideal = 32.0 * 1000.0 * a2 / (1.0 - a2);
    check(real'(out_data) > ideal * 0.995 && real'(out_data) < ideal * 1.005, "R6",
          real'(out_data), ideal);
  endtask

  // R1 R3 R5: impulse right after a reset from a loaded state.
  task automatic t_impulse();
    cur_tag = "R3";
    do_reset();
    push(20000);
    for (int i = 0; i < 32 * 40; i++) push(0);
    idle(6);
  endtask

  // R2: idle clocks between samples do not count.
  task automatic t_gaps();
    cur_tag = "R2";
    do_reset();
    for (int i = 0; i < 32 * 20; i++) begin
      push((i % 3 == 0) ? -3000 : 5000);
      if (i % 2 == 0) idle(1);
      if (i % 7 == 0) idle(2);
    end
    idle(6);
  endtask

  // R8 R9 R10: ratio changes at block ends, clamped requests.
  task automatic t_ratio();
    cur_tag = "R8";
    do_reset();
    for (int i = 0; i < 32 * 5 + 3; i++) push(2000);
    ratio = 4'd7;
    for (int i = 0; i < 28 * 6; i++) push(-1500);
    ratio = 4'd3;                              // clamps to 7: no change (R10)
    for (int i = 0; i < 28 * 4; i++) push(2500);
    ratio = 4'd15;                             // clamps to 9 (R10)
    for (int i = 0; i < 36 * 6; i++) push(700);
    ratio = 4'd8;
    for (int i = 0; i < 32 * 4; i++) push(-700);
    idle(6);
  endtask

  // R11: clamp at both ends of the output range.
  task automatic t_saturate();
    cur_tag = "R11";
    coef_a2 = 16'd32000;
    ratio = 4'd9;
    do_reset();
    for (int i = 0; i < 36 * 100; i++) push(32767);
    idle(6);
    check(out_data == 24'sd8388607, "R11", real'(out_data), 8388607.0);
    for (int i = 0; i < 36 * 100; i++) push(-32768);
    idle(6);
    check(out_data == -24'sd8388608, "R11", real'(out_data), -8388608.0);
    coef_a2 = 16'd28652;
    ratio = 4'd8;
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", real'(out_valid), 0.0);
    check(out_data == '0, "R1", real'(out_data), 0.0);
    rst = 1'b0;
    t_dc();
    t_impulse();
    t_gaps();
    t_ratio();
    t_saturate();
    check(exp_q.size() == 0, "R7", real'(exp_q.size()), 0.0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule